// File: doc/BRIEF.md
# Control Endpoint Mode and Byte-Count Register

This block holds the mode/status register and the byte-count register of a USB control endpoint. Two agents share them. The serial interface engine (SIE) reports finished transactions and the data-phase window of a SETUP transaction. The CPU reads and writes both registers through an I/O port and asks for permission to write the endpoint buffer.

The SIE marks the last token type it received with sticky flags and records a handshake flag. After any SIE update, CPU writes to the low seven bits of the mode register are locked out until the CPU reads that register. The SETUP flag is forced high during the SETUP data phase. After that phase it stays protected until the first CPU read of the mode register. While the SETUP flag is set, buffer writes are refused. The byte count written by the CPU is clamped to the endpoint's maximum packet size.

Top module: `ctl_ep_status`

## Requirements
- R1: After reset, the mode register and the count register read 0x00 and the lock is released (`wr_locked` = 0).
- R2: On `sie_done`, the flag matching `sie_pid` is set and the other flags keep their values. The encodings are `sie_pid` 2'b11 = SETUP (mode bit 7), 2'b10 = IN (bit 6), 2'b01 = OUT (bit 5) and 2'b00 = no token flag.
- R3: On `sie_done` with `sie_ack` = 1, mode bit 4 (handshake flag) is set. Without `sie_ack`, bit 4 keeps its value.
- R4: `sie_done` sets the lock one cycle later. While the lock is set, a CPU write to the mode register (`cpu_sel` = 0) leaves bits 6:0 unchanged, and bit 7 still follows the usual bit-7 rules.
- R5: A CPU read of the mode register in a cycle without `sie_done` releases the lock, and a later CPU write updates bits 6:0.
- R6: When a CPU mode write and `sie_done` arrive in the same cycle, the SIE update is applied, the CPU write is discarded and the lock is set.
- R7: While `sie_setup_win` is high, mode bit 7 is forced to 1 in the next cycle, and no CPU write can clear it.
- R8: After the window closes, bit 7 cannot be cleared by a CPU write until a mode-register read has been made with `sie_setup_win` low. After that read, a write of 0 to bit 7 clears it.
- R9: `buf_wr_refused` = `buf_wr_req` while mode bit 7 is 1, and `buf_wr_ok` = `buf_wr_req` while bit 7 is 0, in the same cycle.
- R10: A CPU write to the count register (`cpu_sel` = 1) stores bits 7:6 (toggle, data valid) as written and bits 5:0 as min(value, 32). The count register is never locked.
- R11: With the lock released and no SETUP protection, a CPU mode write stores all eight bits as written. `cpu_rdata` shows the register picked by `cpu_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sie_done | input | 1 | End-of-transaction strobe from the SIE |
| sie_pid | input | 2 | Token type of the finished transaction |
| sie_ack | input | 1 | Transaction ended with a handshake ACK |
| sie_setup_win | input | 1 | High from the SETUP data phase until the ACK starts |
| cpu_wr | input | 1 | CPU I/O write strobe |
| cpu_rd | input | 1 | CPU I/O read strobe |
| cpu_sel | input | 1 | Register select: 0 mode, 1 count |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Selected register value |
| buf_wr_req | input | 1 | CPU request to write the endpoint buffer |
| buf_wr_ok | output | 1 | Buffer write granted |
| buf_wr_refused | output | 1 | Buffer write refused |
| mode_reg | output | 8 | Mode/status register |
| count_reg | output | 8 | Byte-count register |
| wr_locked | output | 1 | Mode bits 6:0 are locked against CPU writes |

## Verification
Directed sequences step through the lock cycle: write, SIE update, a refused write, a read that unlocks, then a write that takes effect. Further directed cases cover a write that collides with an SIE update, and the SETUP window with its protection lasting past the window. These cases separate a lock that releases on a read from one that releases on a write. They also separate a SETUP guard that is limited to the window from one that lasts until the first read. A long random mix of strobes, token types, window pulses and write data, compared against a bench model, then exercises reads, writes and SIE events landing in the same cycle. Count writes above and below 32 check that saturation acts on the byte field alone and leaves the flag bits alone.

// File: rtl/ep_pkg.sv
package ep_pkg;
    localparam int REG_W   = 8;
    localparam int CNT_W   = 6;
    localparam int MAX_PKT = 32;

    localparam logic [1:0] PID_NONE  = 2'b00;
    localparam logic [1:0] PID_OUT   = 2'b01;
    localparam logic [1:0] PID_IN    = 2'b10;
    localparam logic [1:0] PID_SETUP = 2'b11;

    localparam int BIT_SETUP = 7;
    localparam int BIT_IN    = 6;
    localparam int BIT_OUT   = 5;
    localparam int BIT_ACK   = 4;

    typedef struct packed {
        logic [REG_W-1:0] mode;
        logic             lock;
        logic             hold;
    } mode_st_t;
endpackage

// File: rtl/ep_mode_reg.sv
module ep_mode_reg
    import ep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sie_done,
    input  logic [1:0]       sie_pid,
    input  logic             sie_ack,
    input  logic             sie_setup_win,
    input  logic             mode_wr,
    input  logic             mode_rd,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] mode_q,
    output logic             lock_q
);
    mode_st_t st_d, st_q;
    logic     guard;

    always_comb begin
        st_d  = st_q;
        guard = sie_setup_win || st_q.hold;
        // CPU write, discarded when the SIE updates in the same cycle
        if (mode_wr && !sie_done) begin
            if (!st_q.lock)
                st_d.mode[REG_W-2:0] = wdata[REG_W-2:0];
            st_d.mode[BIT_SETUP] = guard ? (st_q.mode[BIT_SETUP] | wdata[BIT_SETUP])
                                         : wdata[BIT_SETUP];
        end
        // SIE end-of-transaction update
        if (sie_done) begin
            case (sie_pid)
                PID_SETUP: st_d.mode[BIT_SETUP] = 1'b1;
                PID_IN:    st_d.mode[BIT_IN]    = 1'b1;
                PID_OUT:   st_d.mode[BIT_OUT]   = 1'b1;
                default:   ;
            endcase
            if (sie_ack)
                st_d.mode[BIT_ACK] = 1'b1;
            st_d.lock = 1'b1;
        end else if (mode_rd) begin
            st_d.lock = 1'b0;
        end
        // SETUP data-phase window and its protection
        if (sie_setup_win) begin
            st_d.mode[BIT_SETUP] = 1'b1;
            st_d.hold            = 1'b1;
        end else if (mode_rd) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_q = st_q.mode;
    assign lock_q = st_q.lock;

    // R4
    done_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sie_done |=> lock_q);
    // R4
    locked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && lock_q && !sie_done) |=> $stable(mode_q[REG_W-2:0]));
    // R5
    read_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd && !sie_done) |=> !lock_q);
    // R7
    win_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sie_setup_win |=> mode_q[BIT_SETUP]);
    // R8
    guard_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && mode_q[BIT_SETUP]) |=> mode_q[BIT_SETUP]);
endmodule

// File: rtl/ep_count_reg.sv
module ep_count_reg
    import ep_pkg::*;
#(
    parameter int W       = REG_W,
    parameter int CW      = CNT_W,
    parameter int MAX_CNT = MAX_PKT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count_q
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_CNT);

    logic [W-1:0]  cnt_d, cnt_q;
    logic [CW-1:0] bytes_in;

    always_comb begin
        cnt_d    = cnt_q;
        bytes_in = wdata[CW-1:0];
        if (cnt_wr) begin
            cnt_d[W-1:CW] = wdata[W-1:CW];
            cnt_d[CW-1:0] = (bytes_in > LIMIT) ? LIMIT : bytes_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_q = cnt_q;

    // R10
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q[CW-1:0] <= LIMIT);
    // R10
    cnt_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count_q[W-1:CW] == $past(wdata[W-1:CW])));
endmodule

// File: rtl/ep_buf_gate.sv
module ep_buf_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic setup_flag,
    input  logic req,
    output logic ok,
    output logic refused
);
    assign ok      = req && !setup_flag;
    assign refused = req &&  setup_flag;

    // R9
    gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && refused));
    // R9
    gate_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && setup_flag) |-> !ok);
endmodule

// File: rtl/ctl_ep_status.sv
module ctl_ep_status
    import ep_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sie_done,
    input  logic [1:0]       sie_pid,
    input  logic             sie_ack,
    input  logic             sie_setup_win,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic             cpu_sel,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             buf_wr_req,
    output logic             buf_wr_ok,
    output logic             buf_wr_refused,
    output logic [REG_W-1:0] mode_reg,
    output logic [REG_W-1:0] count_reg,
    output logic             wr_locked
);
    logic mode_wr, mode_rd, cnt_wr;

    assign mode_wr = cpu_wr && !cpu_sel;
    assign mode_rd = cpu_rd && !cpu_sel;
    assign cnt_wr  = cpu_wr &&  cpu_sel;

    ep_mode_reg u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .sie_done      (sie_done),
        .sie_pid       (sie_pid),
        .sie_ack       (sie_ack),
        .sie_setup_win (sie_setup_win),
        .mode_wr       (mode_wr),
        .mode_rd       (mode_rd),
        .wdata         (cpu_wdata),
        .mode_q        (mode_reg),
        .lock_q        (wr_locked)
    );

    ep_count_reg #(.W(REG_W), .CW(CNT_W), .MAX_CNT(MAX_PKT)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_wr  (cnt_wr),
        .wdata   (cpu_wdata),
        .count_q (count_reg)
    );

    ep_buf_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .setup_flag (mode_reg[BIT_SETUP]),
        .req        (buf_wr_req),
        .ok         (buf_wr_ok),
        .refused    (buf_wr_refused)
    );

    assign cpu_rdata = cpu_sel ? count_reg : mode_reg;

    // R6
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sie_done && mode_wr) |=> wr_locked);
endmodule

// File: tb/ctl_ep_status_tb.sv
module ctl_ep_status_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sie_done = 0, sie_ack = 0, sie_setup_win = 0;
    logic [1:0] sie_pid = 0;
    logic       cpu_wr = 0, cpu_rd = 0, cpu_sel = 0, buf_wr_req = 0;
    logic [7:0] cpu_wdata = 0;
    logic [7:0] cpu_rdata, mode_reg, count_reg;
    logic       buf_wr_ok, buf_wr_refused, wr_locked;

    int checks = 0, failures = 0;
    logic [7:0] m_mode = 0, m_cnt = 0;
    logic       m_lock = 0, m_hold = 0;

    always #10 clk = ~clk;

    ctl_ep_status u_dut (
        .clk(clk), .rst_n(rst_n), .sie_done(sie_done), .sie_pid(sie_pid),
        .sie_ack(sie_ack), .sie_setup_win(sie_setup_win), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .buf_wr_req(buf_wr_req), .buf_wr_ok(buf_wr_ok),
        .buf_wr_refused(buf_wr_refused), .mode_reg(mode_reg),
        .count_reg(count_reg), .wr_locked(wr_locked)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] sat_cnt(input logic [7:0] w);
        return {w[7:6], (w[5:0] > 6'd32) ? 6'd32 : w[5:0]};
    endfunction

    task automatic model_next();
        logic [7:0] nm;
        logic nl, nh, guard, mw, mr;
        nm = m_mode; nl = m_lock; nh = m_hold;
        guard = sie_setup_win || m_hold;
        mw = cpu_wr && !cpu_sel;
        mr = cpu_rd && !cpu_sel;
        if (mw && !sie_done) begin
            if (!m_lock) nm[6:0] = cpu_wdata[6:0];
            nm[7] = guard ? (m_mode[7] | cpu_wdata[7]) : cpu_wdata[7];
        end
        if (sie_done) begin
            if (sie_pid == 2'b11) nm[7] = 1'b1;
            if (sie_pid == 2'b10) nm[6] = 1'b1;
            if (sie_pid == 2'b01) nm[5] = 1'b1;
            if (sie_ack) nm[4] = 1'b1;
            nl = 1'b1;
        end else if (mr) nl = 1'b0;
        if (sie_setup_win) begin nm[7] = 1'b1; nh = 1'b1; end
        else if (mr) nh = 1'b0;
        if (cpu_wr && cpu_sel) m_cnt = sat_cnt(cpu_wdata);
        m_mode = nm; m_lock = nl; m_hold = nh;
    endtask

    // Called at a negative edge; drives one cycle and checks the result.
    task automatic step(input logic d, input logic [1:0] p, input logic a,
                        input logic w, input logic wr, input logic rd,
                        input logic sel, input logic [7:0] wd,
                        input logic req, input string tag);
        sie_done = d; sie_pid = p; sie_ack = a; sie_setup_win = w;
        cpu_wr = wr; cpu_rd = rd; cpu_sel = sel; cpu_wdata = wd; buf_wr_req = req;
        #1;
        chk({tag, " R9 ok"}, {7'd0, buf_wr_ok}, {7'd0, req && !m_mode[7]});
        chk({tag, " R9 refused"}, {7'd0, buf_wr_refused}, {7'd0, req && m_mode[7]});
        chk({tag, " R11 rdata"}, cpu_rdata, sel ? m_cnt : m_mode);
        model_next();
        @(posedge clk);
        @(negedge clk);
        chk({tag, " mode"}, mode_reg, m_mode);
        chk({tag, " count"}, count_reg, m_cnt);
        chk({tag, " lock"}, {7'd0, wr_locked}, {7'd0, m_lock});
    endtask

    task automatic idle(input string tag);
        step(0, 2'b00, 0, 0, 0, 0, 0, 8'h00, 0, tag);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset mode", mode_reg, 8'h00);
        chk("R1 reset count", count_reg, 8'h00);
        chk("R1 reset lock", {7'd0, wr_locked}, 8'h00);

        step(0, 2'b00, 0, 0, 1, 0, 0, 8'h0F, 0, "R11 plain write");
        chk("R11 value", mode_reg, 8'h0F);
        step(1, 2'b10, 1, 0, 0, 0, 0, 8'h00, 0, "R2 R3 IN done");
        chk("R2 IN flag", mode_reg, 8'h5F);
        chk("R4 locked", {7'd0, wr_locked}, 8'h01);
        step(0, 2'b00, 0, 0, 1, 0, 0, 8'h80, 0, "R4 locked write");
        chk("R4 low bits kept", mode_reg, 8'hDF);
        step(0, 2'b00, 0, 0, 1, 0, 0, 8'h00, 1, "R4 locked clear7");
        chk("R4 bit7 writable", mode_reg, 8'h5F);
        step(1, 2'b00, 0, 0, 0, 0, 0, 8'h00, 0, "R3 no ack");
        chk("R3 ack kept", mode_reg, 8'h5F);
        step(0, 2'b00, 0, 0, 0, 1, 0, 8'h00, 0, "R5 read");
        chk("R5 unlocked", {7'd0, wr_locked}, 8'h00);
        step(0, 2'b00, 0, 0, 1, 0, 0, 8'h03, 0, "R5 write after read");
        chk("R5 value", mode_reg, 8'h03);
        step(1, 2'b01, 0, 0, 1, 0, 0, 8'h7C, 0, "R6 collide");
        chk("R6 SIE wins", mode_reg, 8'h23);
        step(0, 2'b00, 0, 0, 0, 1, 0, 8'h00, 0, "R5 read2");
        step(0, 2'b00, 0, 1, 0, 0, 0, 8'h00, 1, "R7 window");
        chk("R7 forced", mode_reg, 8'hA3);
        step(0, 2'b00, 0, 1, 1, 0, 0, 8'h00, 1, "R7 write in window");
        chk("R7 kept", mode_reg, 8'h80);
        step(1, 2'b11, 1, 0, 0, 0, 0, 8'h00, 1, "R2 SETUP done");
        chk("R2 SETUP flag", mode_reg, 8'h90);
        step(0, 2'b00, 0, 0, 1, 0, 0, 8'h00, 1, "R8 protected write");
        chk("R8 kept", mode_reg, 8'h90);
        step(0, 2'b00, 0, 0, 0, 1, 0, 8'h00, 1, "R8 read");
        step(0, 2'b00, 0, 0, 1, 0, 0, 8'h00, 1, "R8 clear");
        chk("R8 cleared", mode_reg, 8'h00);
        step(0, 2'b00, 0, 0, 1, 0, 1, 8'h3F, 0, "R10 sat");
        chk("R10 sat value", count_reg, 8'h20);
        step(0, 2'b00, 0, 0, 1, 0, 1, 8'hE5, 0, "R10 flags");
        chk("R10 flags value", count_reg, 8'hE0);
        step(1, 2'b01, 0, 0, 0, 0, 0, 8'h00, 0, "R10 lock set");
        step(0, 2'b00, 0, 0, 1, 0, 1, 8'h94, 0, "R10 unlocked count");
        chk("R10 in range", count_reg, 8'h94);
        idle("idle");

        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 8) == 0, 2'($urandom), 1'($urandom),
                 ($urandom % 10) == 0, ($urandom % 3) == 0, ($urandom % 4) == 0,
                 1'($urandom), 8'($urandom), 1'($urandom), "R2 R11 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule